// File: doc/BRIEF.md
# Pixel-Chained Serial Result Readout

This block moves per-pixel 12-bit timing results off a detector array without a wide multiplexed bus. Every pixel owns a result register. On a frame-capture command, all pixel registers load in parallel: a pixel whose result is flagged valid stores that result, and a pixel with no valid result stores a reserved all-ones code. The array then enters its shift phase. Each shift-enable pulse moves every register one bit toward the neighbouring pixel, so a whole column's results stream out of the end of the chain one bit at a time.

The array is split into several column chains that shift side by side, so the bit count of each chain fits inside one frame period at the shift rate. With a 25 MHz shift enable and a 40 µs frame, a chain can carry up to 1000 bits. A frame-start marker is raised with the first bit of each frame. An active flag marks every cycle in which a valid bit is presented. Capture and shift are mutually exclusive phases. A capture command that arrives while a frame is shifting is remembered and carried out as soon as that frame ends.

Top module: `pixel_chain_readout`

## Requirements
- R1: After reset, `ser_active` and `ser_first` are 0 and every `ser_data` bit is 0. While no frame is shifting, `ser_data` stays 0 and `ser_first` stays 0.
- R2: A `frame_cap` high in a cycle with no frame shifting loads all pixel registers at that clock edge. From the next cycle, `ser_active` is 1 and chain c presents bit 11 (the MSB) of pixel c*PIX_PER_CHAIN+PIX_PER_CHAIN-1.
- R3: Pixel i's result is the 12-bit field `pix_result[i*12 +: 12]`, and pixel i belongs to chain i/PIX_PER_CHAIN. Each chain streams its pixels from the highest index down to the lowest, and each result MSB first, one bit per `shift_en` pulse.
- R4: A pixel whose `pix_valid` bit is 0 at the capture edge streams the code 12'hFFF in place of its result.
- R5: A frame lasts exactly PIX_PER_CHAIN*12 `shift_en` pulses. The cycle after the last pulse, `ser_active` is 0.
- R6: `ser_first` is 1 only while the first bit of a frame is presented, and it is 0 from the first shift onward.
- R7: A `frame_cap` raised while a frame is shifting, including in the same cycle as that frame's last shift, does not disturb the frame. The deferred capture takes place in the single idle cycle after the frame ends, using the inputs present in that cycle, so `ser_active` is low for exactly one cycle.
- R8: `shift_en` pulses while no frame is shifting have no effect: the outputs stay idle, and a later capture yields a complete frame from its first bit.
- R9: While `shift_en` is 0 during a frame, the presented bits and flags hold.
- R10: Several `frame_cap` requests during one frame produce exactly one deferred frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_result | input | NUM_CHAINS*PIX_PER_CHAIN*RES_W | Locked timing result of every pixel, pixel i at bits i*RES_W upward |
| pix_valid | input | NUM_CHAINS*PIX_PER_CHAIN | Per-pixel result-valid flags |
| frame_cap | input | 1 | Frame-capture command |
| shift_en | input | 1 | One-cycle shift strobe at the readout rate |
| ser_data | output | NUM_CHAINS | Serial bit of each chain |
| ser_active | output | 1 | A frame bit is being presented |
| ser_first | output | 1 | Presented bit is the first of a frame |

## Verification
Two functions can fall in the same clock cycle: the final shift of a frame and a new capture request. The bench raises `frame_cap` together with the last `shift_en` pulse of a frame. It then requires exactly one idle cycle, followed by a new frame whose first bit carries the marker and whose contents match the inputs held at the deferred capture. A second case issues two requests in mid-frame and checks that they result in one frame only.

// File: rtl/readout_pkg.sv
package readout_pkg;
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;
endpackage

// File: rtl/readout_seq.sv
module readout_seq
    import readout_pkg::*;
#(
    parameter int TOTAL_BITS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_req,
    input  logic shift_en,
    output logic load,
    output logic shift,
    output logic active,
    output logic first
);
    localparam int CW = $clog2(TOTAL_BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(TOTAL_BITS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        phase_e        phase;
        logic          pend;
        logic [CW-1:0] rem;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        shift = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (cap_req || st_q.pend) begin
                    load       = 1'b1;
                    st_d.phase = PH_SHIFT;
                    st_d.pend  = 1'b0;
                    st_d.rem   = FULL;
                end
            end
            default: begin
                if (cap_req) st_d.pend = 1'b1;
                if (shift_en) begin
                    shift = 1'b1;
                    if (st_q.rem == ONE) begin
                        st_d.phase = PH_IDLE;
                        st_d.rem   = '0;
                    end else begin
                        st_d.rem = st_q.rem - ONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, pend: 1'b0, rem: '0};
        else        st_q <= st_d;
    end

    assign active = (st_q.phase == PH_SHIFT);
    assign first  = active && (st_q.rem == FULL);
endmodule

// File: rtl/readout_lane.sv
module readout_lane #(
    parameter int PIX_PER_CHAIN = 4,
    parameter int RES_W         = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic                           shift,
    input  logic [PIX_PER_CHAIN*RES_W-1:0] res,
    input  logic [PIX_PER_CHAIN-1:0]       vld,
    output logic                           sout
);
    localparam int LEN = PIX_PER_CHAIN * RES_W;

    typedef struct packed {
        logic [LEN-1:0] sr;
    } lane_t;

    lane_t st_d, st_q;
    logic [LEN-1:0] cap_vec;

    // Each pixel offers its locked result, or the all-ones code when invalid.
    for (genvar k = 0; k < PIX_PER_CHAIN; k++) begin : g_pix
        assign cap_vec[k*RES_W +: RES_W] = vld[k] ? res[k*RES_W +: RES_W] : {RES_W{1'b1}};
    end

    always_comb begin
        st_d = st_q;
        if (load)       st_d.sr = cap_vec;
        else if (shift) st_d.sr = {st_q.sr[LEN-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: '0};
        else        st_q <= st_d;
    end

    assign sout = st_q.sr[LEN-1];
endmodule

// File: rtl/pixel_chain_readout.sv
module pixel_chain_readout #(
    parameter int NUM_CHAINS    = 2,
    parameter int PIX_PER_CHAIN = 4,
    parameter int RES_W         = 12
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_CHAINS*PIX_PER_CHAIN*RES_W-1:0] pix_result,
    input  logic [NUM_CHAINS*PIX_PER_CHAIN-1:0]       pix_valid,
    input  logic                                      frame_cap,
    input  logic                                      shift_en,
    output logic [NUM_CHAINS-1:0]                     ser_data,
    output logic                                      ser_active,
    output logic                                      ser_first
);
    localparam int CHAIN_BITS = PIX_PER_CHAIN * RES_W;

    logic                  load, shift, active, first;
    logic [NUM_CHAINS-1:0] lane_out;

    readout_seq #(.TOTAL_BITS(CHAIN_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_req  (frame_cap),
        .shift_en (shift_en),
        .load     (load),
        .shift    (shift),
        .active   (active),
        .first    (first)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_lane
        readout_lane #(.PIX_PER_CHAIN(PIX_PER_CHAIN), .RES_W(RES_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .shift (shift),
            .res   (pix_result[c*CHAIN_BITS +: CHAIN_BITS]),
            .vld   (pix_valid[c*PIX_PER_CHAIN +: PIX_PER_CHAIN]),
            .sout  (lane_out[c])
        );
        assign ser_data[c] = active & lane_out[c];
    end

    assign ser_active = active;
    assign ser_first  = first;
endmodule

// File: rtl/readout_chk.sv
module readout_chk #(
    parameter int NUM_CHAINS    = 2,
    parameter int PIX_PER_CHAIN = 4,
    parameter int RES_W         = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_cap,
    input logic                  shift_en,
    input logic [NUM_CHAINS-1:0] ser_data,
    input logic                  ser_active,
    input logic                  ser_first
);
    localparam int BITS = PIX_PER_CHAIN * RES_W;
    localparam int CW   = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!ser_active) cnt_q <= '0;
        else if (shift_en)   cnt_q <= cnt_q + CW'(1);
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_active |-> (ser_data == '0 && !ser_first));

    p_cap_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_active && frame_cap) |=> ser_active);

    p_len_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_active && !(shift_en && cnt_q == LAST)) |=> ser_active);

    p_len_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_active && shift_en && cnt_q == LAST) |=> !ser_active);

    p_first_onset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_active) |-> ser_first);

    p_first_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_first |-> (ser_active && cnt_q == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_active && !shift_en) |=> (ser_active && $stable(ser_data) && $stable(ser_first)));
endmodule

bind pixel_chain_readout readout_chk #(
    .NUM_CHAINS    (NUM_CHAINS),
    .PIX_PER_CHAIN (PIX_PER_CHAIN),
    .RES_W         (RES_W)
) u_readout_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_cap  (frame_cap),
    .shift_en   (shift_en),
    .ser_data   (ser_data),
    .ser_active (ser_active),
    .ser_first  (ser_first)
);

// File: tb/test_pixel_chain_readout.sv
module test_pixel_chain_readout;
    localparam int NCH  = 2;
    localparam int P    = 4;
    localparam int W    = 12;
    localparam int NPIX = NCH * P;
    localparam int BITS = P * W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPIX*W-1:0] pix_result = '0;
    logic [NPIX-1:0]   pix_valid = '0;
    logic              frame_cap = 1'b0;
    logic              shift_en = 1'b0;
    logic [NCH-1:0]    ser_data;
    logic              ser_active;
    logic              ser_first;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] snap_res [NPIX];
    logic         snap_vld [NPIX];

    always #2 clk = ~clk;

    pixel_chain_readout #(.NUM_CHAINS(NCH), .PIX_PER_CHAIN(P), .RES_W(W)) i_pixel_chain_readout (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_result (pix_result),
        .pix_valid  (pix_valid),
        .frame_cap  (frame_cap),
        .shift_en   (shift_en),
        .ser_data   (ser_data),
        .ser_active (ser_active),
        .ser_first  (ser_first)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic snapshot();
        for (int i = 0; i < NPIX; i++) begin
            snap_res[i] = pix_result[i*W +: W];
            snap_vld[i] = pix_valid[i];
        end
    endtask

    function automatic logic exp_bit(int c, int b);
        int k = P - 1 - b / W;
        int pos = W - 1 - b % W;
        int i = c * P + k;
        logic [W-1:0] v = snap_vld[i] ? snap_res[i] : {W{1'b1}};
        return v[pos];
    endfunction

    task automatic check_bit(int b, string req);
        chk(ser_active == 1'b1, "R5 active during frame", int'(ser_active), 1);
        chk(ser_first == (b == 0), "R6 first marker", int'(ser_first), int'(b == 0));
        for (int c = 0; c < NCH; c++)
            chk(ser_data[c] == exp_bit(c, b), req, int'(ser_data[c]), int'(exp_bit(c, b)));
    endtask

    // Expects a frame to be presenting its first bit at the current negedge.
    task automatic run_frame(int gap, int cap_at, int cap_cnt, string req);
        for (int b = 0; b < BITS; b++) begin
            check_bit(b, req);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check_bit(b, "R9 hold without shift");
            end
            shift_en = 1'b1;
            frame_cap = (b >= cap_at && b < cap_at + cap_cnt);
            @(negedge clk);
            shift_en = 1'b0;
            frame_cap = 1'b0;
        end
        chk(ser_active == 1'b0, "R5 frame ends after last shift", int'(ser_active), 0);
        chk(ser_data == '0, "R1 idle data zero", int'(ser_data), 0);
    endtask

    task automatic capture();
        frame_cap = 1'b1;
        snapshot();
        @(negedge clk);
        frame_cap = 1'b0;
        chk(ser_active && ser_first, "R2 capture starts frame", int'({ser_active, ser_first}), 3);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ser_active == 1'b0, "R1 reset active", int'(ser_active), 0);
        chk(ser_first == 1'b0, "R1 reset first", int'(ser_first), 0);
        chk(ser_data == '0, "R1 reset data", int'(ser_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_active == 1'b0, "R1 idle after reset", int'(ser_active), 0);
    endtask

    task automatic t_all_valid();
        for (int i = 0; i < NPIX; i++) pix_result[i*W +: W] = W'(12'h5A3 + i * 12'h111);
        pix_valid = '1;
        capture();
        run_frame(0, -10, 0, "R3 stream order all valid");
        @(negedge clk);
    endtask

    task automatic t_invalid();
        for (int i = 0; i < NPIX; i++) pix_result[i*W +: W] = W'(12'h013 * (i + 1));
        pix_valid = 8'b1010_0110;
        capture();
        run_frame(0, -10, 0, "R4 invalid pixel all ones");
        @(negedge clk);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < NPIX; i++) pix_result[i*W +: W] = W'(12'hC0F ^ (i << 3));
        pix_valid = 8'b0111_1110;
        capture();
        run_frame(2, -10, 0, "R3 stream with gaps");
        @(negedge clk);
    endtask

    task automatic t_idle_shift();
        for (int n = 0; n < 5; n++) begin
            shift_en = 1'b1;
            @(negedge clk);
            chk(!ser_active && ser_data == '0 && !ser_first, "R8 idle shift ignored",
                int'({ser_active, ser_first, ser_data}), 0);
        end
        shift_en = 1'b0;
        for (int i = 0; i < NPIX; i++) pix_result[i*W +: W] = W'(12'h800 >> i);
        pix_valid = '1;
        capture();
        run_frame(0, -10, 0, "R8 full frame after idle shifts");
        @(negedge clk);
    endtask

    task automatic t_defer_last();
        for (int i = 0; i < NPIX; i++) pix_result[i*W +: W] = W'(12'h3C5 + i);
        pix_valid = '1;
        capture();
        for (int i = 0; i < NPIX; i++) pix_result[i*W +: W] = W'(12'hA50 - i * 7);
        pix_valid = 8'b1101_1011;
        run_frame(0, BITS - 1, 1, "R7 frame intact with late request");
        @(negedge clk);
        snapshot();
        chk(ser_active && ser_first, "R7 deferred frame after one idle cycle",
            int'({ser_active, ser_first}), 3);
        run_frame(0, -10, 0, "R7 deferred frame contents");
        @(negedge clk);
    endtask

    task automatic t_defer_multi();
        for (int i = 0; i < NPIX; i++) pix_result[i*W +: W] = W'(12'h111 * (i + 2));
        pix_valid = '1;
        capture();
        for (int i = 0; i < NPIX; i++) pix_result[i*W +: W] = W'(12'hF0E - (i << 4));
        pix_valid = 8'b0011_1100;
        run_frame(0, 5, 2, "R10 frame intact with mid requests");
        @(negedge clk);
        snapshot();
        chk(ser_active && ser_first, "R10 one deferred frame starts", int'({ser_active, ser_first}), 3);
        run_frame(0, -10, 0, "R10 deferred frame contents");
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(ser_active == 1'b0, "R10 no extra frame", int'(ser_active), 0);
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_all_valid();
        t_invalid();
        t_gaps();
        t_idle_shift();
        t_defer_last();
        t_defer_multi();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule